// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder Model

This block is a synthesizable stand-in for a small three-wire serial EEPROM of 128 bytes. A host master drives chip select, a serial clock and a serial data line. The block samples them on its own system clock, decodes each instruction frame and answers on a serial data output. The storage array lives in registers inside the block. Its organisation and the extended-instruction option are set by two static inputs. The organisation gives either 128 bytes or 64 words of 16 bits.

A frame opens with a start bit, which is the first 1 seen while the select line is high. Two opcode bits and an address follow. The supported operations are read, word write, enabling writes, disabling writes and erasing the whole array. Writes and erase-all only change the array while a write-enable latch is set. They are committed when the select line falls, and they start a programming interval whose length is set by the `PROG_CYCLES` parameter. During that interval the output is held low. When it ends the output reads high. A read streams words out one after another for as long as the select line stays high.

Top module: `mw_eeprom`

## Requirements
- R1: While the block waits for a frame, every 0 sampled on a rising serial-clock edge is ignored. The first 1 is the start bit, and the two bits after it are the opcode: 10 read, 01 write, 00 control.
- R2: The address has 7 bits when `org16` is 0 and 6 bits when it is 1, sent MSB first. After the last address bit of a read, the output shows a 0 dummy bit. Each following serial-clock rise then presents the next data bit, MSB first: 8 bits per word in byte mode and 16 bits in word mode.
- R3: While select stays high, a read moves on to the next address after each complete word. It wraps from the last address (0x7F in byte mode, 0x3F in word mode) back to 0.
- R4: After reset the write-enable latch is clear and the array holds 0xFF in every byte. A write or erase-all issued while the latch is clear leaves the array unchanged and starts no programming interval.
- R5: A control frame whose two top address bits are 11 sets the latch. One whose top bits are 00 clears it.
- R6: A write frame carries one data word after its address, MSB first. The write is committed on the falling edge of select only if the whole word has been received. In word mode the high byte goes to byte address 2*A and the low byte to 2*A+1.
- R7: A control frame whose two top address bits are 10 sets all 128 bytes to 0xFF when select falls.
- R8: When `ext_ops` is 1, a control frame needs two further serial-clock bits after its address. If select falls before they arrive, the command has no effect.
- R9: A committed write or erase-all holds the output low for `PROG_CYCLES` clocks. After that the output is high until the next start bit is accepted.
- R10: Start bits that arrive during the programming interval are ignored, so a whole frame sent in that time has no effect.
- R11: A falling select aborts any partly received frame and returns the block to waiting for a start bit.
- R12: After reset the output is low and no programming interval is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| org16 | input | 1 | Static organisation select: 0 byte words, 1 sixteen-bit words |
| ext_ops | input | 1 | Static option: control frames take two extra clock bits |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data / ready indication to the master |

## Verification
A decoder that loses its bit count shows up on the first read that follows. The dummy bit or the data lines up one position off, and the word read back no longer matches the word written a few hundred clocks earlier. A wrong write-enable latch or a wrong busy state is visible within one programming interval. The output either goes high when no programming should have happened, or it stays low when programming should have ended. A wrong wrap or a wrong byte order in the array only appears when the master reads across the end of the array, or reads a 16-bit word back as bytes. The bench therefore does both explicitly.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int MW_BW = 8;
    localparam int MW_DW = 16;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_OPC   = 4'd1,
        S_ADDR  = 4'd2,
        S_EXTRA = 4'd3,
        S_WDATA = 4'd4,
        S_WHOLD = 4'd5,
        S_EHOLD = 4'd6,
        S_READ  = 4'd7,
        S_SKIP  = 4'd8
    } mw_state_e;

    localparam logic [1:0] OPC_CTL = 2'b00;
    localparam logic [1:0] OPC_WR  = 2'b01;
    localparam logic [1:0] OPC_RD  = 2'b10;

    localparam logic [1:0] SUB_DIS = 2'b00;
    localparam logic [1:0] SUB_ERA = 2'b10;
    localparam logic [1:0] SUB_EN  = 2'b11;

endpackage

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int PROG_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int BYTES = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     org16,
    input  logic [$clog2(BYTES)-1:0] rd_addr,
    output logic [MW_DW-1:0]         rd_word,
    input  logic                     wr_go,
    input  logic [$clog2(BYTES)-1:0] wr_addr,
    input  logic [MW_DW-1:0]         wr_data,
    input  logic                     era_go
);
    localparam int AW8 = $clog2(BYTES);

    logic [MW_BW-1:0] mem_d [BYTES];
    logic [MW_BW-1:0] mem_q [BYTES];

    logic [AW8-1:0] rd_hi, rd_lo, wr_hi, wr_lo;

    assign rd_hi = {rd_addr[AW8-2:0], 1'b0};
    assign rd_lo = {rd_addr[AW8-2:0], 1'b1};
    assign wr_hi = {wr_addr[AW8-2:0], 1'b0};
    assign wr_lo = {wr_addr[AW8-2:0], 1'b1};

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            mem_d[i] = era_go ? {MW_BW{1'b1}} : mem_q[i];
        end
        if (wr_go && !era_go) begin
            if (org16) begin
                mem_d[wr_hi] = wr_data[MW_DW-1:MW_BW];
                mem_d[wr_lo] = wr_data[MW_BW-1:0];
            end else begin
                mem_d[wr_addr] = wr_data[MW_BW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= {MW_BW{1'b1}};
            end
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word = org16 ? {mem_q[rd_hi], mem_q[rd_lo]}
                           : {mem_q[rd_addr], {MW_BW{1'b0}}};

endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int AW8 = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               org16,
    input  logic               ext_ops,
    input  logic               cs,
    input  logic               sk,
    input  logic               sdi,
    input  logic               busy,
    input  logic               done,
    input  logic [MW_DW-1:0]   rd_word,
    output logic [AW8-1:0]     rd_addr,
    output logic               wr_go,
    output logic               era_go,
    output logic [AW8-1:0]     wr_addr,
    output logic [MW_DW-1:0]   wr_data,
    output logic               ewen,
    output logic               ready,
    output logic               rd_active,
    output logic               rd_bit,
    output logic               idle
);
    localparam int CNTW = $clog2(MW_DW) + 1;
    localparam logic [CNTW-1:0] AWM1_B = CNTW'(AW8 - 1);
    localparam logic [CNTW-1:0] AWM1_W = CNTW'(AW8 - 2);
    localparam logic [CNTW-1:0] DWM1_B = CNTW'(MW_BW - 1);
    localparam logic [CNTW-1:0] DWM1_W = CNTW'(MW_DW - 1);
    localparam logic [AW8-1:0]  MASK_W = {1'b0, {(AW8-1){1'b1}}};

    typedef struct packed {
        mw_state_e        st;
        logic [CNTW-1:0]  cnt;
        logic [1:0]       opc;
        logic [AW8-1:0]   addr;
        logic [MW_DW-1:0] sh;
        logic             ewen;
        logic             ready;
        logic             dummy;
        logic             ld;
        logic             sk;
        logic             cs;
    } frame_t;

    frame_t q, n;

    logic           sk_rise, cs_fall, do_ctl;
    logic [CNTW-1:0] aw_m1, dw_m1;
    logic [AW8-1:0] a_in, a_nx;
    logic [1:0]     sub_in, sub_q, sub_sel;

    always_comb begin
        sk_rise = sk & ~q.sk;
        cs_fall = q.cs & ~cs;
        aw_m1   = org16 ? AWM1_W : AWM1_B;
        dw_m1   = org16 ? DWM1_W : DWM1_B;
        a_in    = {q.addr[AW8-2:0], sdi};
        a_nx    = q.addr + 1'b1;
        if (org16) begin
            a_in = a_in & MASK_W;
            a_nx = a_nx & MASK_W;
        end
        sub_in  = org16 ? a_in[AW8-2 -: 2] : a_in[AW8-1 -: 2];
        sub_q   = org16 ? q.addr[AW8-2 -: 2] : q.addr[AW8-1 -: 2];
        sub_sel = (q.st == S_EXTRA) ? sub_q : sub_in;

        n      = q;
        n.sk   = sk;
        n.cs   = cs;
        wr_go  = 1'b0;
        era_go = 1'b0;
        do_ctl = 1'b0;

        if (done) begin
            n.ready = 1'b1;
        end
        if (q.ld) begin
            n.sh = rd_word;
            n.ld = 1'b0;
        end

        if (!cs) begin
            n.st    = S_IDLE;
            n.cnt   = '0;
            n.dummy = 1'b0;
            n.ld    = 1'b0;
            if (cs_fall && q.ewen) begin
                wr_go  = (q.st == S_WHOLD);
                era_go = (q.st == S_EHOLD);
            end
        end else if (sk_rise) begin
            case (q.st)
                S_IDLE: begin
                    if (!busy && sdi) begin
                        n.st    = S_OPC;
                        n.cnt   = '0;
                        n.ready = 1'b0;
                    end
                end
                S_OPC: begin
                    n.opc = {q.opc[0], sdi};
                    if (q.cnt == CNTW'(1)) begin
                        n.st  = S_ADDR;
                        n.cnt = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                S_ADDR: begin
                    n.addr = a_in;
                    if (q.cnt == aw_m1) begin
                        n.cnt = '0;
                        case (q.opc)
                            OPC_RD: begin
                                n.st    = S_READ;
                                n.dummy = 1'b1;
                                n.ld    = 1'b1;
                            end
                            OPC_WR:  n.st = S_WDATA;
                            OPC_CTL: begin
                                if (ext_ops) begin
                                    n.st = S_EXTRA;
                                end else begin
                                    do_ctl = 1'b1;
                                end
                            end
                            default: n.st = S_SKIP;
                        endcase
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                S_EXTRA: begin
                    if (q.cnt == CNTW'(1)) begin
                        do_ctl = 1'b1;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                S_WDATA: begin
                    n.sh = {q.sh[MW_DW-2:0], sdi};
                    if (q.cnt == dw_m1) begin
                        n.st = S_WHOLD;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                S_READ: begin
                    if (q.dummy) begin
                        n.dummy = 1'b0;
                    end else if (q.cnt == dw_m1) begin
                        n.cnt  = '0;
                        n.addr = a_nx;
                        n.ld   = 1'b1;
                    end else begin
                        n.sh  = {q.sh[MW_DW-2:0], 1'b0};
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase

            if (do_ctl) begin
                n.st = S_SKIP;
                case (sub_sel)
                    SUB_EN:  n.ewen = 1'b1;
                    SUB_DIS: n.ewen = 1'b0;
                    SUB_ERA: n.st   = S_EHOLD;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rd_addr   = q.addr;
    assign wr_addr   = q.addr;
    assign wr_data   = org16 ? q.sh : {{(MW_DW-MW_BW){1'b0}}, q.sh[MW_BW-1:0]};
    assign ewen      = q.ewen;
    assign ready     = q.ready;
    assign rd_active = (q.st == S_READ);
    assign rd_bit    = q.dummy ? 1'b0 : q.sh[MW_DW-1];
    assign idle      = (q.st == S_IDLE);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int MEM_BYTES   = 128,
    parameter int PROG_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org16,
    input  logic ext_ops,
    input  logic cs,
    input  logic sk,
    input  logic sdi,
    output logic sdo
);
    localparam int AW8 = $clog2(MEM_BYTES);

    logic [MW_DW-1:0] rd_word, wr_data;
    logic [AW8-1:0]   rd_addr, wr_addr;
    logic             wr_go, era_go, ewen, ready, rd_active, rd_bit, fr_idle;
    logic             prog_busy, prog_done;

    mw_frame #(.AW8(AW8)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .org16    (org16),
        .ext_ops  (ext_ops),
        .cs       (cs),
        .sk       (sk),
        .sdi      (sdi),
        .busy     (prog_busy),
        .done     (prog_done),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .wr_go    (wr_go),
        .era_go   (era_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ewen     (ewen),
        .ready    (ready),
        .rd_active(rd_active),
        .rd_bit   (rd_bit),
        .idle     (fr_idle)
    );

    mw_array #(.BYTES(MEM_BYTES)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .org16  (org16),
        .rd_addr(rd_addr),
        .rd_word(rd_word),
        .wr_go  (wr_go),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .era_go (era_go)
    );

    mw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wr_go | era_go),
        .busy (prog_busy),
        .done (prog_done)
    );

    assign sdo = prog_busy ? 1'b0 : (rd_active ? rd_bit : ready);

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdo,
    input logic busy,
    input logic wr_go,
    input logic era_go,
    input logic ewen,
    input logic rd_active,
    input logic idle
);
    AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> ewen); // R4
    AST_ERA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        era_go |-> ewen); // R7
    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go || era_go) |=> busy); // R9
    AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sdo); // R9
    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(wr_go || era_go)); // R10
    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> !busy); // R10
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> idle); // R11
    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !sdo); // R2
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .sdo      (sdo),
    .busy     (prog_busy),
    .wr_go    (wr_go),
    .era_go   (era_go),
    .ewen     (ewen),
    .rd_active(rd_active),
    .idle     (fr_idle)
);

// File: tb/sim_mw_eeprom.sv
`timescale 1ns/1ps
module sim_mw_eeprom;

    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n, org16, ext_ops, cs, sk, sdi;
    logic sdo;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] shm [128];

    // {org16, address, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 8'h00, 16'h00A5},
        {1'b0, 8'h7F, 16'h003C},
        {1'b1, 8'h00, 16'h1234},
        {1'b1, 8'h3F, 16'hBEEF},
        {1'b0, 8'h41, 16'h0081},
        {1'b1, 8'h15, 16'h5AC3}
    };

    always #10 clk = ~clk;

    mw_eeprom #(.MEM_BYTES(128), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .org16(org16), .ext_ops(ext_ops),
        .cs(cs), .sk(sk), .sdi(sdi), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        tick(1);
        sk = 1'b1;
        tick(2);
        sk = 1'b0;
        tick(2);
    endtask

    task automatic bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    function automatic int awid();
        return org16 ? 6 : 7;
    endfunction

    function automatic int dwid();
        return org16 ? 16 : 8;
    endfunction

    task automatic sel();
        cs = 1'b1;
        tick(2);
    endtask

    task automatic desel();
        cs  = 1'b0;
        sdi = 1'b0;
        tick(2);
    endtask

    task automatic ctl(input logic [1:0] sub);
        sel();
        bits(3'b100, 3);
        bits(32'(sub) << (awid() - 2), awid());
        if (ext_ops) bits(0, 2);
        desel();
    endtask

    task automatic wr_frame(input logic [6:0] a, input logic [15:0] d);
        sel();
        bits(3'b101, 3);
        bits(32'(a), awid());
        bits(32'(d), dwid());
        desel();
    endtask

    task automatic rd_start(input logic [6:0] a);
        sel();
        bits(3'b110, 3);
        bits(32'(a), awid());
        chk(sdo == 1'b0, "R2 dummy bit", 32'(sdo), 0);
    endtask

    task automatic rd_word(output logic [15:0] w);
        w = '0;
        for (int i = 0; i < dwid(); i++) begin
            bit_out(1'b0);
            w = {w[14:0], sdo};
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [6:0] a);
        if (org16) return {shm[{a[5:0], 1'b0}], shm[{a[5:0], 1'b1}]};
        return {8'h00, shm[a]};
    endfunction

    task automatic put(input logic [6:0] a, input logic [15:0] d);
        if (org16) begin
            shm[{a[5:0], 1'b0}] = d[15:8];
            shm[{a[5:0], 1'b1}] = d[7:0];
        end else begin
            shm[a] = d[7:0];
        end
    endtask

    task automatic read_chk(input logic [6:0] a, input string tag);
        logic [15:0] w;
        rd_start(a);
        rd_word(w);
        desel();
        chk(w == exp_word(a), tag, 32'(w), 32'(exp_word(a)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        for (int i = 0; i < 128; i++) shm[i] = 8'hFF;
        rst_n = 1'b0; org16 = 1'b0; ext_ops = 1'b0;
        cs = 1'b0; sk = 1'b0; sdi = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R12 reset output
        chk(sdo == 1'b0, "R12 sdo after reset", 32'(sdo), 0);

        // R4 latch clear after reset: write ignored, no busy/ready
        wr_frame(7'h03, 16'h0055);
        tick(PROG + 4);
        chk(sdo == 1'b0, "R4 no programming without enable", 32'(sdo), 0);
        read_chk(7'h03, "R4 erased reset content kept");

        // R5 enable, then vector table of writes and readbacks
        ctl(2'b11);
        for (int v = 0; v < 6; v++) begin
            org16 = VEC[v][24];
            wr_frame(VEC[v][22:16], VEC[v][15:0]);
            tick(3);
            chk(sdo == 1'b0, "R9 busy after commit", 32'(sdo), 0);
            tick(PROG);
            chk(sdo == 1'b1, "R9 ready after programming", 32'(sdo), 1);
            put(VEC[v][22:16], VEC[v][15:0]);
            read_chk(VEC[v][22:16], "R6 write readback");
        end

        // R10 frame during busy ignored
        org16 = 1'b0;
        wr_frame(7'h41, 16'h0022);
        put(7'h41, 16'h0022);
        tick(3);
        wr_frame(7'h41, 16'h0077);
        tick(PROG + 4);
        read_chk(7'h41, "R10 write during busy ignored");

        // R3 sequential read with wrap, byte mode
        rd_start(7'h7E);
        for (int k = 0; k < 4; k++) begin
            rd_word(w);
            chk(w == exp_word(7'((8'h7E + k) & 8'h7F)), "R3 byte stream wrap", 32'(w),
                32'(exp_word(7'((8'h7E + k) & 8'h7F))));
        end
        desel();

        // R3 wrap in word mode
        org16 = 1'b1;
        rd_start(7'h3F);
        rd_word(w);
        chk(w == exp_word(7'h3F), "R3 word at top", 32'(w), 32'(exp_word(7'h3F)));
        rd_word(w);
        chk(w == exp_word(7'h00), "R3 word wrap to 0", 32'(w), 32'(exp_word(7'h00)));
        desel();

        // R1 leading zeros before start bit
        sel();
        bits(0, 3);
        bits(3'b110, 3);
        bits(32'h15, 6);
        rd_word(w);
        desel();
        chk(w == exp_word(7'h15), "R1 leading zeros ignored", 32'(w), 32'(exp_word(7'h15)));

        // R11 aborted write
        org16 = 1'b0;
        sel();
        bits(3'b101, 3);
        bits(32'h10, 7);
        bits(4'b0101, 4);
        desel();
        tick(PROG + 4);
        chk(sdo == 1'b0, "R11 abort starts no programming", 32'(sdo), 0);
        read_chk(7'h10, "R11 abort leaves data");

        // R5 disable blocks write
        ctl(2'b00);
        wr_frame(7'h20, 16'h0099);
        tick(PROG + 4);
        chk(sdo == 1'b0, "R5 disabled write not programmed", 32'(sdo), 0);
        read_chk(7'h20, "R5 disabled write no change");

        // R8 extended control frames
        ext_ops = 1'b1;
        sel();
        bits(3'b100, 3);
        bits(32'h60, 7);
        desel();
        wr_frame(7'h21, 16'h0044);
        tick(PROG + 4);
        chk(sdo == 1'b0, "R8 short enable has no effect", 32'(sdo), 0);
        read_chk(7'h21, "R8 short enable data kept");
        ctl(2'b11);
        wr_frame(7'h21, 16'h0044);
        put(7'h21, 16'h0044);
        tick(PROG + 4);
        chk(sdo == 1'b1, "R8 full enable allows write", 32'(sdo), 1);
        read_chk(7'h21, "R8 write after full enable");

        // R6 byte order of a 16-bit word
        org16 = 1'b1;
        wr_frame(7'h05, 16'hA1B2);
        put(7'h05, 16'hA1B2);
        tick(PROG + 4);
        org16 = 1'b0;
        rd_start(7'h0A);
        rd_word(w);
        chk(w == 16'h00A1, "R6 high byte at even address", 32'(w), 32'h00A1);
        rd_word(w);
        chk(w == 16'h00B2, "R6 low byte at odd address", 32'(w), 32'h00B2);
        desel();

        // R7 erase-all
        ctl(2'b10);
        tick(3);
        chk(sdo == 1'b0, "R7 busy during erase", 32'(sdo), 0);
        tick(PROG);
        chk(sdo == 1'b1, "R7 ready after erase", 32'(sdo), 1);
        for (int i = 0; i < 128; i++) shm[i] = 8'hFF;
        read_chk(7'h00, "R7 byte 0 erased");
        read_chk(7'h41, "R7 byte 0x41 erased");
        read_chk(7'h7F, "R7 last byte erased");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule